// File: doc/BRIEF.md
# Serial Divider Configuration Loader

This block takes a three-wire serial stream (bit clock, data, load strobe) from a controller and turns it into the configuration of a frequency synthesizer's dividers. Bits enter a 19-bit shift register on each rising edge of the serial bit clock. A rising edge on the load strobe copies the register into one of two holding sets. The last bit shifted in chooses the set.

The reference set holds a 14-bit reference divide ratio and four mode bits: prescaler modulus select, phase-detector polarity, monitor-output select and charge-pump current select. The counter set holds a 7-bit swallow count and an 11-bit main count. All three serial lines are brought into the system clock domain through two-flop synchronisers and are sampled there.

A frame that asks for a reference or main ratio below 3 is not allowed. Such a frame is dropped, and a sticky error flag is raised.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset the outputs are ref_div=3, main_div=3, swallow=0, all four mode bits 0, and cfg_err=0.
- R2: Each rising edge of ser_clk shifts ser_dat into the register. Bits are sent MSB first. The last bit shifted in (frame bit 0) is the control bit.
- R3: With control bit 1, a load updates the reference set. Frame bits 14..1 give ref_div (bit 1 is the LSB). Bit 15 gives pre_sel, bit 16 phase_inv, bit 17 mon_sel and bit 18 cp_hi.
- R4: With control bit 0, a load updates the counter set. Frame bits 7..1 give swallow (bit 1 is the LSB), and frame bits 18..8 give main_div (bit 8 is the LSB).
- R5: A load happens only on a rising edge of ser_le. The set that the control bit does not select keeps its value.
- R6: Edges of ser_clk while ser_le is high do not change the shift register.
- R7: A reference frame with a ratio below 3 leaves the whole reference set unchanged and sets cfg_err. cfg_err then stays set until reset.
- R8: A counter frame with a main ratio below 3 leaves the whole counter set unchanged and sets cfg_err.
- R9: When more than 19 bits are shifted before a load, only the last 19 bits count.
- R10: The boundary values are accepted: ref_div 3 and 16383, main_div 3 and 2047, and swallow 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data |
| ser_le | input | 1 | Load strobe |
| ref_div | output | 14 | Reference divide ratio |
| pre_sel | output | 1 | Prescaler modulus select |
| phase_inv | output | 1 | Phase-detector polarity |
| mon_sel | output | 1 | Monitor output select |
| cp_hi | output | 1 | Charge-pump high-current select |
| swallow | output | 7 | Swallow count |
| main_div | output | 11 | Main counter ratio |
| cfg_err | output | 1 | Sticky illegal-ratio flag |

## Verification
The assertions assume that each serial line holds its level for more than two system clocks. This lets every edge pass through the synchronisers and be seen exactly once. They also assume that ser_dat is stable around each ser_clk rise, and that ser_le is not raised in the middle of a bit.

The stimulus holds every level for at least three system clocks. It changes data only while ser_clk is low, and it raises ser_le only after the final bit's clock has fallen.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int RW = 14,
  parameter int AW = 7,
  parameter int NW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_le,
  output logic [RW-1:0] ref_div,
  output logic          pre_sel,
  output logic          phase_inv,
  output logic          mon_sel,
  output logic          cp_hi,
  output logic [AW-1:0] swallow,
  output logic [NW-1:0] main_div,
  output logic          cfg_err
);
  localparam int FW = 1 + AW + NW;

  logic [2:0]    clk_q, le_q;
  logic [1:0]    dat_q;
  logic [FW-1:0] sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_q <= '0;
      le_q  <= '0;
      dat_q <= '0;
    end else begin
      clk_q <= {clk_q[1:0], ser_clk};
      le_q  <= {le_q[1:0], ser_le};
      dat_q <= {dat_q[0], ser_dat};
    end

  wire sclk_rise = clk_q[1] & ~clk_q[2];
  wire le_rise   = le_q[1] & ~le_q[2];
  wire le_high   = le_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      sr <= '0;
    else if (sclk_rise && !le_high)
      sr <= {sr[FW-2:0], dat_q[1]};

  wire          is_ref = sr[0];
  wire [RW-1:0] r_fld  = sr[RW:1];
  wire [AW-1:0] a_fld  = sr[AW:1];
  wire [NW-1:0] n_fld  = sr[FW-1:AW+1];
  wire          r_ok   = r_fld >= RW'(3);
  wire          n_ok   = n_fld >= NW'(3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_div   <= RW'(3);
      pre_sel   <= 1'b0;
      phase_inv <= 1'b0;
      mon_sel   <= 1'b0;
      cp_hi     <= 1'b0;
      swallow   <= '0;
      main_div  <= NW'(3);
      cfg_err   <= 1'b0;
    end else if (le_rise) begin
      if (is_ref) begin
        if (r_ok) begin
          ref_div   <= r_fld;
          pre_sel   <= sr[RW+1];
          phase_inv <= sr[RW+2];
          mon_sel   <= sr[RW+3];
          cp_hi     <= sr[RW+4];
        end else
          cfg_err <= 1'b1;
      end else begin
        if (n_ok) begin
          swallow  <= a_fld;
          main_div <= n_fld;
        end else
          cfg_err <= 1'b1;
      end
    end

  assert_ref_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_div >= RW'(3));
  assert_main_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    main_div >= NW'(3));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  assert_load_only_on_le_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable({ref_div, pre_sel, phase_inv, mon_sel, cp_hi, swallow, main_div}));
  assert_cnt_keeps_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !is_ref) |=> $stable({ref_div, pre_sel, phase_inv, mon_sel, cp_hi}));
  assert_le_freezes_sr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (le_high && $past(le_high)) |-> $stable(sr));
endmodule

// File: tb/sim_serial_cfg_loader.sv
module sim_serial_cfg_loader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
  logic [13:0] ref_div;
  logic [6:0]  swallow;
  logic [10:0] main_div;
  logic pre_sel, phase_inv, mon_sel, cp_hi, cfg_err;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_loader u0 (.clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_dat(sdat), .ser_le(sle),
    .ref_div(ref_div), .pre_sel(pre_sel), .phase_inv(phase_inv), .mon_sel(mon_sel), .cp_hi(cp_hi),
    .swallow(swallow), .main_div(main_div), .cfg_err(cfg_err));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdat = b; wait_clk(3);
    sclk = 1'b1; wait_clk(3);
    sclk = 1'b0; wait_clk(2);
  endtask

  task automatic send_frame(input logic [18:0] f);
    for (int i = 18; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_le();
    sle = 1'b1; wait_clk(4);
    sle = 1'b0; wait_clk(4);
  endtask

  function automatic logic [18:0] ref_frame(input logic [13:0] r, input logic [3:0] m);
    return {m[3], m[2], m[1], m[0], r, 1'b1};
  endfunction

  function automatic logic [18:0] cnt_frame(input logic [6:0] a, input logic [10:0] n);
    return {n, a, 1'b0};
  endfunction

  task automatic check_ref(input string req, input int r, input logic [3:0] m);
    check(req, ref_div, r);
    check(req, {cp_hi, mon_sel, phase_inv, pre_sel}, m);
  endtask

  task automatic t_reset_R1();
    check_ref("R1", 3, 4'b0000);
    check("R1", swallow, 0);
    check("R1", main_div, 3);
    check("R1", cfg_err, 0);
  endtask

  task automatic t_ref_R3();
    send_frame(ref_frame(14'h2ABC, 4'b1010)); pulse_le();
    check_ref("R3", 14'h2ABC, 4'b1010);
    check("R5", main_div, 3);
    check("R5", swallow, 0);
  endtask

  task automatic t_cnt_R4();
    send_frame(cnt_frame(7'h55, 11'h5A3)); pulse_le();
    check("R4", swallow, 7'h55);
    check("R4", main_div, 11'h5A3);
    check_ref("R5", 14'h2ABC, 4'b1010);
  endtask

  task automatic t_order_R2();
    send_frame(ref_frame(14'h0005, 4'b0001)); pulse_le();
    check_ref("R2", 5, 4'b0001);
  endtask

  task automatic t_le_high_R6();
    send_frame(ref_frame(14'd100, 4'b1111));
    sle = 1'b1; wait_clk(4);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    sle = 1'b0; wait_clk(4);
    check_ref("R6", 100, 4'b1111);
    pulse_le();
    check_ref("R6", 100, 4'b1111);
  endtask

  task automatic t_no_le_R5();
    send_frame(cnt_frame(7'h12, 11'd700));
    wait_clk(10);
    check("R5", main_div, 11'h5A3);
    pulse_le();
    check("R5", main_div, 700);
  endtask

  task automatic t_long_R9();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_frame(cnt_frame(7'd9, 11'd40)); pulse_le();
    check("R9", swallow, 9);
    check("R9", main_div, 40);
  endtask

  task automatic t_bad_n_R8();
    send_frame(cnt_frame(7'd77, 11'd2)); pulse_le();
    check("R8", swallow, 9);
    check("R8", main_div, 40);
    check("R8", cfg_err, 1);
  endtask

  task automatic t_bad_r_R7();
    send_frame(ref_frame(14'd2, 4'b0000)); pulse_le();
    check_ref("R7", 100, 4'b1111);
    check("R7", cfg_err, 1);
    send_frame(ref_frame(14'd50, 4'b0100)); pulse_le();
    check_ref("R7", 50, 4'b0100);
    check("R7", cfg_err, 1);
  endtask

  task automatic t_bounds_R10();
    send_frame(ref_frame(14'd3, 4'b0000)); pulse_le();
    check_ref("R10", 3, 4'b0000);
    send_frame(ref_frame(14'd16383, 4'b1111)); pulse_le();
    check_ref("R10", 16383, 4'b1111);
    send_frame(cnt_frame(7'd127, 11'd3)); pulse_le();
    check("R10", swallow, 127);
    check("R10", main_div, 3);
    send_frame(cnt_frame(7'd0, 11'd2047)); pulse_le();
    check("R10", swallow, 0);
    check("R10", main_div, 2047);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset_R1();
    t_ref_R3();
    t_cnt_R4();
    t_order_R2();
    t_le_high_R6();
    t_no_le_R5();
    t_long_R9();
    t_bad_n_R8();
    t_bad_r_R7();
    t_bounds_R10();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule